// File: doc/BRIEF.md
# Clock-enable and memory wait-state controller

This block holds one 8-bit control word that sets the pace of a small processor subsystem. From a single free-running oscillator clock it produces two clock-enable strobes: one for the processor core and one for a serial transceiver. Every downstream register stays on the oscillator clock and advances only when its strobe is high, so the block never creates a derived clock. The processor strobe runs at the full oscillator rate or at half that rate. The transceiver strobe runs at the full rate, half rate or quarter rate. It can instead follow the rising edges of an external clock pin, which the block synchronises into the oscillator domain first.

The same control word also sets two wait-state counts, one for instruction fetches and one for data accesses. A memory requester raises its request and holds it. The block keeps the matching ready low for the programmed number of cycles and then raises it. A count of zero gives ready in the same cycle as the request.

Changes to a divider selection take effect only at the end of the current strobe period. As a result, a reprogramming never produces a shortened period.

Top module: `clkws_ctrl`

## Requirements
- R1: After reset the control word reads 0x00. Both strobes are high on every cycle. Each ready rises in the same cycle as its request.
- R2: A write cycle (`cfg_we` high) loads `cfg_wdata`, and `cfg_rdata` shows the new value from the next cycle on. The bit fields are: bit 7 selects the processor rate, bits 6:5 select the transceiver source, bits 4:3 hold the instruction wait states, and bits 2:0 hold the data wait states.
- R3: With bit 7 at 0, `cpu_en` is high every cycle. With bit 7 at 1, `cpu_en` is high on every second cycle.
- R4: With bits 6:5 at 00, 01 or 10, `xcvr_en` pulses with a period of 1, 2 or 4 cycles respectively.
- R5: With bits 6:5 at 11, `xcvr_en` gives exactly one single-cycle pulse per rising edge of `ext_tclk`. If `ext_tclk` rises in cycle c, the pulse is in cycle c+2. Falling edges produce no pulse.
- R6: A new rate selection is adopted only at the next pulse of the strobe it controls, and no period before that pulse is shortened. In external mode, that next pulse is the next external rising edge.
- R7: An instruction request (`imem_req` held high) sees `imem_rdy` rise after exactly N cycles, where N = bits 4:3 (0 to 3). N = 0 gives ready in the request cycle.
- R8: A data request (`dmem_req` held high) sees `dmem_rdy` rise after exactly N cycles, where N = bits 2:0 (0 to 7).
- R9: The wait-state count is captured when an access starts. Rewriting the field while the access is pending does not change that access.
- R10: Dropping a request before ready abandons the access. The next request waits its full count again. A ready is never high without its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all state is on this clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Current control word |
| ext_tclk | input | 1 | External transceiver clock, asynchronous |
| cpu_en | output | 1 | Processor clock-enable strobe |
| xcvr_en | output | 1 | Transceiver clock-enable strobe |
| imem_req | input | 1 | Instruction memory access request |
| imem_rdy | output | 1 | Instruction memory access ready |
| dmem_req | input | 1 | Data memory access request |
| dmem_rdy | output | 1 | Data memory access ready |

## Verification
Each result has a fixed due cycle:
- Register readback is due one cycle after the write.
- A divider change shows up at the first strobe after the write. The strobe spacing is then measured between successive pulses rather than at absolute times.
- An external rising edge appears on `xcvr_en` two cycles after the cycle in which the pin was raised.
- Ready is due exactly N cycles after the request is raised.

The bench drives all inputs at falling edges and samples at falling edges. For the combinational same-cycle ready, it samples one nanosecond after driving the request. Every wait-state count and every rate code is swept, and the expected periods and delays are computed as powers of two and as field values.

// File: rtl/clkws_pkg.sv
package clkws_pkg;
  localparam int CFG_W     = 8;
  localparam int CPU_SEL_W = 1;
  localparam int XCV_SEL_W = 2;
  localparam int IWS_W     = 2;
  localparam int DWS_W     = 3;

  typedef struct packed {
    logic                 cpu_sel;
    logic [XCV_SEL_W-1:0] xcv_sel;
    logic [IWS_W-1:0]     iws;
    logic [DWS_W-1:0]     dws;
  } cfg_t;

  // Strobe period, in oscillator cycles, for a rate code.
  function automatic int unsigned period_of(input int unsigned code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/cw_cfg_reg.sv
module cw_cfg_reg
  import clkws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && $past(rst_n)) |=> $stable(q));
endmodule

// File: rtl/cw_enable_gen.sv
module cw_enable_gen
  import clkws_pkg::*;
#(
  parameter int SEL_W  = 1,
  parameter bit EXT_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_req,
  input  logic             ext_tick,
  output logic             en
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] act_sel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic             is_ext;
  logic             tc;

  generate
    if (EXT_EN) begin : g_ext
      assign is_ext = (act_sel == {SEL_W{1'b1}});
    end else begin : g_noext
      assign is_ext = 1'b0;
    end
  endgenerate

  assign term = CNT_W'(period_of(32'(act_sel)) - 1);
  assign tc   = is_ext ? ext_tick : (cnt == term);
  assign en   = tc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_sel <= '0;
    end else if (tc) begin
      cnt     <= '0;
      act_sel <= sel_req;
    end else if (!is_ext) begin
      cnt     <= cnt + CNT_W'(1);
    end
  end

  // Checker state: cycles since the previous strobe, saturating.
  logic [3:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)           gap <= '0;
    else if (en)          gap <= '0;
    else if (gap != 4'hf) gap <= gap + 4'd1;
  end

  // R6
  no_short_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !is_ext) |-> (32'(gap) >= period_of(32'(act_sel)) - 1));
  // R3
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ext && act_sel == '0) |-> en);
endmodule

// File: rtl/cw_wait_seq.sv
module cw_wait_seq #(
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [WS_W-1:0] ws,
  output logic            rdy
);
  logic            busy;
  logic [WS_W-1:0] cnt;

  assign rdy = req && (busy ? (cnt == '0) : (ws == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!req) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - WS_W'(1);
    end else if (ws != '0) begin
      busy <= 1'b1;
      cnt  <= ws - WS_W'(1);
    end
  end

  // Checker state: stall cycles of the current request and its captured count.
  logic [7:0]      stall;
  logic [WS_W-1:0] lat_ws;
  logic [WS_W-1:0] due_ws;
  assign due_ws = (stall == '0) ? ws : lat_ws;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall  <= '0;
      lat_ws <= '0;
    end else begin
      if (req && stall == '0) lat_ws <= ws;
      if (!req || rdy)        stall  <= '0;
      else                    stall  <= stall + 8'd1;
    end
  end

  // R7, R8, R9
  ready_on_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (stall == 8'(due_ws)));
  // R7, R8
  no_overstall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !rdy) |-> (stall < 8'(due_ws)));
  // R10
  rdy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> req);
endmodule

// File: rtl/clkws_ctrl.sv
module clkws_ctrl
  import clkws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             ext_tclk,
  output logic             cpu_en,
  output logic             xcvr_en,
  input  logic             imem_req,
  output logic             imem_rdy,
  input  logic             dmem_req,
  output logic             dmem_rdy
);
  cfg_t cfg;
  assign cfg = cfg_t'(cfg_rdata);

  cw_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_rdata)
  );

  // Two-stage synchroniser plus edge detector for the external clock.
  logic ext_s1, ext_s2, ext_s3, ext_tick;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_s1 <= 1'b0;
      ext_s2 <= 1'b0;
      ext_s3 <= 1'b0;
    end else begin
      ext_s1 <= ext_tclk;
      ext_s2 <= ext_s1;
      ext_s3 <= ext_s2;
    end
  end
  assign ext_tick = ext_s2 && !ext_s3;

  // R5
  ext_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick);

  cw_enable_gen #(.SEL_W(CPU_SEL_W), .EXT_EN(1'b0)) u_cpu_div (
    .clk(clk), .rst_n(rst_n), .sel_req(cfg.cpu_sel), .ext_tick(1'b0), .en(cpu_en)
  );

  cw_enable_gen #(.SEL_W(XCV_SEL_W), .EXT_EN(1'b1)) u_xcv_div (
    .clk(clk), .rst_n(rst_n), .sel_req(cfg.xcv_sel), .ext_tick(ext_tick), .en(xcvr_en)
  );

  cw_wait_seq #(.WS_W(IWS_W)) u_iws (
    .clk(clk), .rst_n(rst_n), .req(imem_req), .ws(cfg.iws), .rdy(imem_rdy)
  );

  cw_wait_seq #(.WS_W(DWS_W)) u_dws (
    .clk(clk), .rst_n(rst_n), .req(dmem_req), .ws(cfg.dws), .rdy(dmem_rdy)
  );
endmodule

// File: tb/test_clkws_ctrl.sv
module test_clkws_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       ext_tclk = 1'b0;
  logic       cpu_en, xcvr_en;
  logic       imem_req = 1'b0, imem_rdy;
  logic       dmem_req = 1'b0, dmem_rdy;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  clkws_ctrl i_clkws_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ext_tclk(ext_tclk), .cpu_en(cpu_en), .xcvr_en(xcvr_en),
    .imem_req(imem_req), .imem_rdy(imem_rdy), .dmem_req(dmem_req), .dmem_rdy(dmem_rdy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_rdata == v, "R2 readback", cfg_rdata, v);
  endtask

  // Find a pulse, then require three successive gaps equal to per.
  task automatic measure(input bit use_cpu, input int per, input string req);
    int k;
    repeat (20) @(negedge clk);
    k = 0;
    while (!(use_cpu ? cpu_en : xcvr_en) && k < 12) begin @(negedge clk); k++; end
    for (int p = 0; p < 3; p++) begin
      k = 0;
      do begin @(negedge clk); k++; end while (!(use_cpu ? cpu_en : xcvr_en) && k < 12);
      check(k == per, req, k, per);
    end
  endtask

  task automatic access(input bit is_d, input int n, input string req);
    int k;
    @(negedge clk);
    if (is_d) dmem_req = 1'b1; else imem_req = 1'b1;
    #1;
    k = 0;
    while (!(is_d ? dmem_rdy : imem_rdy) && k < 20) begin @(negedge clk); k++; end
    check(k == n, req, k, n);
    imem_req = 1'b0; dmem_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfg_rdata == 8'h00, "R1 reset word", cfg_rdata, 0);
    check(cpu_en == 1'b1, "R1 cpu_en in reset", cpu_en, 1);
    check(xcvr_en == 1'b1, "R1 xcvr_en in reset", xcvr_en, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_en && xcvr_en, "R1 full rate after reset", cpu_en & xcvr_en, 1);
    access(1'b0, 0, "R1 imem zero wait");
    access(1'b1, 0, "R1 dmem zero wait");

    // R3, R4 sweep of divider codes
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 3; x++) begin
        write_cfg(8'((c << 7) | (x << 5)));
        measure(1'b1, 1 << c, "R3 cpu period");
        measure(1'b0, 1 << x, "R4 xcvr period");
      end
    end

    // R6: divide-by-4 switched to divide-by-1 right after a pulse
    write_cfg(8'h40);
    repeat (10) @(negedge clk);
    while (!xcvr_en) @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'h00;
    @(negedge clk); cfg_we = 1'b0;
    check(xcvr_en == 1'b0, "R6 no early pulse t+1", xcvr_en, 0);
    @(negedge clk); check(xcvr_en == 1'b0, "R6 no early pulse t+2", xcvr_en, 0);
    @(negedge clk); check(xcvr_en == 1'b0, "R6 no early pulse t+3", xcvr_en, 0);
    @(negedge clk); check(xcvr_en == 1'b1, "R6 old period ends t+4", xcvr_en, 1);
    @(negedge clk); check(xcvr_en == 1'b1, "R6 new rate t+5", xcvr_en, 1);

    // R5 external clock mode
    write_cfg(8'h60);
    repeat (12) @(negedge clk);
    for (int e = 0; e < 3; e++) begin
      @(negedge clk); ext_tclk = 1'b1;
      @(negedge clk); check(xcvr_en == 1'b0, "R5 ext c+1", xcvr_en, 0);
      @(negedge clk); check(xcvr_en == 1'b1, "R5 ext c+2", xcvr_en, 1);
      @(negedge clk); check(xcvr_en == 1'b0, "R5 ext c+3", xcvr_en, 0);
      ext_tclk = 1'b0;
      for (int w = 0; w < 4; w++) begin
        @(negedge clk); check(xcvr_en == 1'b0, "R5 falling edge silent", xcvr_en, 0);
      end
    end
    // R6 leaving external mode waits for the next external edge
    write_cfg(8'h00);
    for (int w = 0; w < 5; w++) begin
      @(negedge clk); check(xcvr_en == 1'b0, "R6 ext held", xcvr_en, 0);
    end
    ext_tclk = 1'b1;
    @(negedge clk);
    @(negedge clk); check(xcvr_en == 1'b1, "R6 ext final pulse", xcvr_en, 1);
    @(negedge clk); check(xcvr_en == 1'b1, "R6 full rate after ext", xcvr_en, 1);
    ext_tclk = 1'b0;

    // R7, R8 sweep of wait-state counts
    for (int i = 0; i < 4; i++) begin
      write_cfg(8'(i << 3));
      access(1'b0, i, "R7 imem wait");
    end
    for (int d = 0; d < 8; d++) begin
      write_cfg(8'(d));
      access(1'b1, d, "R8 dmem wait");
    end

    // R9 change during a pending access
    begin
      int k;
      write_cfg(8'h05);
      @(negedge clk); dmem_req = 1'b1;
      k = 0;
      while (!dmem_rdy && k < 20) begin
        @(negedge clk); k++;
        if (k == 1) begin cfg_we = 1'b1; cfg_wdata = 8'h01; end
        else cfg_we = 1'b0;
      end
      cfg_we = 1'b0;
      check(k == 5, "R9 captured count", k, 5);
      dmem_req = 1'b0;
      access(1'b1, 1, "R9 new count next access");
    end

    // R10 abandoned access
    write_cfg(8'h03);
    @(negedge clk); dmem_req = 1'b1;
    @(negedge clk); check(dmem_rdy == 1'b0, "R10 still waiting", dmem_rdy, 0);
    dmem_req = 1'b0; #1;
    check(dmem_rdy == 1'b0, "R10 no ready without request", dmem_rdy, 0);
    repeat (2) @(negedge clk);
    access(1'b1, 3, "R10 full count after abandon");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule